// File: doc/BRIEF.md
# Time and Date Alarm Comparator

This block watches a running BCD clock and calendar and raises an alarm when the current moment matches a programmed alarm setting. It holds two alarm words. The time word covers seconds, minutes, and the hour with its AM/PM bit. The calendar word covers month and day-of-month. Each field has its own enable bit, and only enabled fields are compared. The alarm condition is the logical AND of the enabled field matches. The condition is evaluated once per one-second strobe. When it holds, a sticky alarm flag is set, and the flag stays set until an alarm-clear strobe arrives.

Software loads each alarm word with a one-cycle write strobe. The block checks the word before storing it. A word that carries an illegal value in an enabled field is refused, so the previous setting stays in force, and a per-word "bad entry" flag is raised. The next legal write to that word clears the flag. The time counters themselves and the combining of interrupts are handled by neighbouring logic.

Top module: `tac_alarm_cmp`

## Requirements
- R1: After reset, `alarm_flag`, `tim_bad` and `cal_bad` are 0, and both stored alarm words are 0 with all field enables cleared.
- R2: The time word is loaded when `tim_wr` is high. It holds seconds in bits 6:0 with enable bit 7, minutes in bits 14:8 with enable bit 15, hours in bits 21:16, AM/PM in bit 22 (1 = PM) and hour enable bit 23. An enabled hour field matches only when both the hour and the AM/PM bit match.
- R3: The calendar word is loaded when `cal_wr` is high. It holds month in bits 20:16 with enable bit 23, and date in bits 29:24 with enable bit 31.
- R4: The alarm condition is the AND of the matches of all enabled fields. A disabled field has no effect, whatever the current value of that field.
- R5: The condition is sampled only in a cycle where `sec_tick` is high. `alarm_flag` rises on the clock edge that samples such a cycle, and never rises in a cycle without a tick.
- R6: `alarm_flag` stays at 1 until `alarm_clr` is high at a clock edge. When `alarm_clr` and a matching tick arrive together, the flag ends up at 1.
- R7: A time write is illegal if an enabled field is non-BCD, if seconds or minutes exceed 0x59, or if the hour exceeds 0x23. In the 12-hour variant, the hour must be 0x01 to 0x12. Values in disabled fields are not checked. An illegal write sets `tim_bad`, and a legal write clears it.
- R8: A calendar write is illegal if an enabled month is not BCD 0x01 to 0x12, or if an enabled date is not BCD 0x01 to 0x31. An illegal write sets `cal_bad`, and a legal write clears it.
- R9: When all five field enables are 0, the alarm never fires.
- R10: A refused word is not stored. The alarm keeps matching the last legal setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_pm | input | 1 | Current AM/PM indicator, 1 = PM |
| cur_month | input | 5 | Current month, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle strobe once per second |
| tim_wr | input | 1 | Load strobe for the time alarm word |
| tim_word | input | WORD_W | Time alarm word |
| cal_wr | input | 1 | Load strobe for the calendar alarm word |
| cal_word | input | WORD_W | Calendar alarm word |
| alarm_clr | input | 1 | Clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| tim_bad | output | 1 | Last time alarm write was refused |
| cal_bad | output | 1 | Last calendar alarm write was refused |

## Verification
Two functions can act in the same clock cycle: the clear strobe and a matching one-second tick. In that case the flag update must choose setting over clearing. The bench drives `alarm_clr` and a matching `sec_tick` in one cycle and expects the flag to read 1 afterwards. A clear on its own must still read 0. The bench also writes a new alarm word in the same cycle as a tick, and expects the comparison to use the previously stored setting.

// File: rtl/tac_pkg.sv
package tac_pkg;

   // bit positions of the alarm words (software-visible layout)
   localparam int SEC_LO  = 0;
   localparam int SEC_EN  = 7;
   localparam int MIN_LO  = 8;
   localparam int MIN_EN  = 15;
   localparam int HR_LO   = 16;
   localparam int HR_PM   = 22;
   localparam int HR_EN   = 23;
   localparam int MON_LO  = 16;
   localparam int MON_EN  = 23;
   localparam int DAT_LO  = 24;
   localparam int DAT_EN  = 31;

   localparam int SEC_W   = 7;
   localparam int MIN_W   = 7;
   localparam int HR_W    = 6;
   localparam int MON_W   = 5;
   localparam int DAT_W   = 6;
   localparam int MIN_WORD_W = 32;

   typedef struct packed {
      logic             sec_en;
      logic [SEC_W-1:0] sec;
      logic             min_en;
      logic [MIN_W-1:0] min;
      logic             hr_en;
      logic             pm;
      logic [HR_W-1:0]  hr;
   } tim_alarm_t;

   typedef struct packed {
      logic             mon_en;
      logic [MON_W-1:0] mon;
      logic             dat_en;
      logic [DAT_W-1:0] dat;
   } cal_alarm_t;

   // both nibbles hold a decimal digit
   function automatic logic bcd_ok(input logic [7:0] v);
      return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
   endfunction

   // BCD value within an inclusive BCD range (BCD orders like binary)
   function automatic logic bcd_in(input logic [7:0] v,
                                   input logic [7:0] lo,
                                   input logic [7:0] hi);
      return bcd_ok(v) && (v >= lo) && (v <= hi);
   endfunction

endpackage

// File: rtl/tac_field_eq.sv
module tac_field_eq #(
   parameter int W = 7
) (
   input  logic         en,
   input  logic [W-1:0] alarm_val,
   input  logic [W-1:0] cur_val,
   output logic         hit
);
   if (W < 1) begin : g_bad_w
      $error("tac_field_eq: W must be positive");
   end

   // a disabled field never blocks the match
   assign hit = !en || (alarm_val == cur_val);
endmodule

// File: rtl/tac_time_check.sv
module tac_time_check
   import tac_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter bit HOUR12 = 1'b0
) (
   input  logic [WORD_W-1:0] word,
   output tim_alarm_t        fields,
   output logic              legal
);
   if (WORD_W < MIN_WORD_W) begin : g_bad_w
      $error("tac_time_check: WORD_W too small");
   end

   logic sec_ok, min_ok, hr_ok;
   logic [7:0] sec8, min8, hr8;

   always_comb begin
      fields.sec_en = word[SEC_EN];
      fields.sec    = word[SEC_LO +: SEC_W];
      fields.min_en = word[MIN_EN];
      fields.min    = word[MIN_LO +: MIN_W];
      fields.hr_en  = word[HR_EN];
      fields.pm     = word[HR_PM];
      fields.hr     = word[HR_LO +: HR_W];
   end

   assign sec8 = {1'b0, fields.sec};
   assign min8 = {1'b0, fields.min};
   assign hr8  = {2'b00, fields.hr};

   assign sec_ok = !fields.sec_en || bcd_in(sec8, 8'h00, 8'h59);
   assign min_ok = !fields.min_en || bcd_in(min8, 8'h00, 8'h59);

   if (HOUR12) begin : g_h12
      assign hr_ok = !fields.hr_en || bcd_in(hr8, 8'h01, 8'h12);
   end else begin : g_h24
      assign hr_ok = !fields.hr_en || bcd_in(hr8, 8'h00, 8'h23);
   end

   assign legal = sec_ok && min_ok && hr_ok;
endmodule

// File: rtl/tac_cal_check.sv
module tac_cal_check
   import tac_pkg::*;
#(
   parameter int         WORD_W   = 32,
   parameter logic [7:0] DATE_MAX = 8'h31
) (
   input  logic [WORD_W-1:0] word,
   output cal_alarm_t        fields,
   output logic              legal
);
   if (WORD_W < MIN_WORD_W) begin : g_bad_w
      $error("tac_cal_check: WORD_W too small");
   end
   if (!(DATE_MAX[3:0] <= 4'd9 && DATE_MAX[7:4] <= 4'd3)) begin : g_bad_max
      $error("tac_cal_check: DATE_MAX must be BCD up to 0x39");
   end

   logic [7:0] mon8, dat8;

   always_comb begin
      fields.mon_en = word[MON_EN];
      fields.mon    = word[MON_LO +: MON_W];
      fields.dat_en = word[DAT_EN];
      fields.dat    = word[DAT_LO +: DAT_W];
   end

   assign mon8  = {3'b000, fields.mon};
   assign dat8  = {2'b00, fields.dat};
   assign legal = (!fields.mon_en || bcd_in(mon8, 8'h01, 8'h12)) &&
                  (!fields.dat_en || bcd_in(dat8, 8'h01, DATE_MAX));
endmodule

// File: rtl/tac_alarm_cmp.sv
module tac_alarm_cmp
   import tac_pkg::*;
#(
   parameter int         WORD_W   = 32,
   parameter bit         HOUR12   = 1'b0,
   parameter logic [7:0] DATE_MAX = 8'h31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [6:0]        cur_sec,
   input  logic [6:0]        cur_min,
   input  logic [5:0]        cur_hour,
   input  logic              cur_pm,
   input  logic [4:0]        cur_month,
   input  logic [5:0]        cur_date,
   input  logic              sec_tick,
   input  logic              tim_wr,
   input  logic [WORD_W-1:0] tim_word,
   input  logic              cal_wr,
   input  logic [WORD_W-1:0] cal_word,
   input  logic              alarm_clr,
   output logic              alarm_flag,
   output logic              tim_bad,
   output logic              cal_bad
);
   localparam int NFIELD = 5;

   if (WORD_W < MIN_WORD_W) begin : g_bad_w
      $error("tac_alarm_cmp: WORD_W must be at least 32");
   end

   tim_alarm_t tim_next, tim_q;
   cal_alarm_t cal_next, cal_q;
   logic       tim_legal, cal_legal;
   logic [NFIELD-1:0] hits;
   logic       any_en, fire;

   tac_time_check #(.WORD_W(WORD_W), .HOUR12(HOUR12)) u_tchk (
      .word(tim_word), .fields(tim_next), .legal(tim_legal));

   tac_cal_check #(.WORD_W(WORD_W), .DATE_MAX(DATE_MAX)) u_cchk (
      .word(cal_word), .fields(cal_next), .legal(cal_legal));

   // stored alarm words and entry-validity flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tim_q   <= '0;
         cal_q   <= '0;
         tim_bad <= 1'b0;
         cal_bad <= 1'b0;
      end else begin
         if (tim_wr) begin
            if (tim_legal) tim_q <= tim_next;
            tim_bad <= !tim_legal;
         end
         if (cal_wr) begin
            if (cal_legal) cal_q <= cal_next;
            cal_bad <= !cal_legal;
         end
      end
   end

   tac_field_eq #(.W(SEC_W)) u_sec (
      .en(tim_q.sec_en), .alarm_val(tim_q.sec), .cur_val(cur_sec), .hit(hits[0]));
   tac_field_eq #(.W(MIN_W)) u_min (
      .en(tim_q.min_en), .alarm_val(tim_q.min), .cur_val(cur_min), .hit(hits[1]));
   tac_field_eq #(.W(HR_W+1)) u_hr (
      .en(tim_q.hr_en), .alarm_val({tim_q.pm, tim_q.hr}),
      .cur_val({cur_pm, cur_hour}), .hit(hits[2]));
   tac_field_eq #(.W(MON_W)) u_mon (
      .en(cal_q.mon_en), .alarm_val(cal_q.mon), .cur_val(cur_month), .hit(hits[3]));
   tac_field_eq #(.W(DAT_W)) u_dat (
      .en(cal_q.dat_en), .alarm_val(cal_q.dat), .cur_val(cur_date), .hit(hits[4]));

   assign any_en = tim_q.sec_en | tim_q.min_en | tim_q.hr_en |
                   cal_q.mon_en | cal_q.dat_en;
   assign fire   = any_en && (&hits);

   // sticky flag; a new match outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                alarm_flag <= 1'b0;
      else if (sec_tick && fire) alarm_flag <= 1'b1;
      else if (alarm_clr)        alarm_flag <= 1'b0;
   end

   // R6: flag holds without a clear
   a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_flag && !alarm_clr |=> alarm_flag);
   // R6: matching tick wins over clear
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick && fire |=> alarm_flag);
   // R5: no rise without a tick
   a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_tick |=> !$rose(alarm_flag));
   // R9: no enables, no alarm
   a_r9_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick && !any_en |=> !$rose(alarm_flag));
   // R10: refused words leave storage untouched
   a_r10_keep_time: assert property (@(posedge clk) disable iff (!rst_n)
      tim_wr && !tim_legal |=> $stable(tim_q));
   a_r10_keep_cal: assert property (@(posedge clk) disable iff (!rst_n)
      cal_wr && !cal_legal |=> $stable(cal_q));
   // R7 / R8: validity flags track the checkers after each write
   a_r7_time_flag: assert property (@(posedge clk) disable iff (!rst_n)
      tim_wr |=> tim_bad != $past(tim_legal));
   a_r8_cal_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cal_wr |=> cal_bad != $past(cal_legal));
endmodule

// File: tb/tac_alarm_cmp_bench.sv
module tac_alarm_cmp_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [6:0] cur_sec = '0, cur_min = '0;
   logic [5:0] cur_hour = '0;
   logic cur_pm = 1'b0;
   logic [4:0] cur_month = '0;
   logic [5:0] cur_date = '0;
   logic sec_tick = 1'b0, tim_wr = 1'b0, cal_wr = 1'b0, alarm_clr = 1'b0;
   logic [31:0] tim_word = '0, cal_word = '0;
   logic alarm_flag, tim_bad, cal_bad;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   tac_alarm_cmp u_tac_alarm_cmp (
      .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .cur_min(cur_min),
      .cur_hour(cur_hour), .cur_pm(cur_pm), .cur_month(cur_month),
      .cur_date(cur_date), .sec_tick(sec_tick), .tim_wr(tim_wr),
      .tim_word(tim_word), .cal_wr(cal_wr), .cal_word(cal_word),
      .alarm_clr(alarm_clr), .alarm_flag(alarm_flag), .tim_bad(tim_bad),
      .cal_bad(cal_bad));

   function automatic logic [31:0] tw(input logic sen, input logic [6:0] s,
      input logic men, input logic [6:0] m, input logic hen, input logic pm,
      input logic [5:0] h);
      return {8'h00, hen, pm, h, men, m, sen, s};
   endfunction

   function automatic logic [31:0] cw(input logic men, input logic [4:0] mo,
      input logic den, input logic [5:0] d);
      return {den, 1'b0, d, men, 2'b00, mo, 16'h0000};
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b", req, act, exp);
      end
   endtask

   // one clock edge with the strobes currently driven, then release them
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      sec_tick = 1'b0; tim_wr = 1'b0; cal_wr = 1'b0; alarm_clr = 1'b0;
   endtask

   task automatic wr_tim(input logic [31:0] w);
      tim_word = w; tim_wr = 1'b1; step();
   endtask

   task automatic wr_cal(input logic [31:0] w);
      cal_word = w; cal_wr = 1'b1; step();
   endtask

   task automatic tick();
      sec_tick = 1'b1; step();
   endtask

   task automatic clr();
      alarm_clr = 1'b1; step();
   endtask

   task automatic t_reset();
      chk("R1 flag", alarm_flag, 1'b0);
      chk("R1 tim_bad", tim_bad, 1'b0);
      chk("R1 cal_bad", cal_bad, 1'b0);
      tick();
      chk("R1 R9 zero enables after reset", alarm_flag, 1'b0);
   endtask

   task automatic t_seconds();
      wr_tim(tw(1'b1, 7'h30, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00));
      cur_sec = 7'h30;
      step();
      chk("R5 no tick no rise", alarm_flag, 1'b0);
      tick();
      chk("R2 seconds match", alarm_flag, 1'b1);
      cur_sec = 7'h31;
      tick();
      chk("R6 sticky", alarm_flag, 1'b1);
      clr();
      chk("R6 clear", alarm_flag, 1'b0);
      cur_sec = 7'h30;
      alarm_clr = 1'b1; sec_tick = 1'b1; step();
      chk("R6 set beats clear", alarm_flag, 1'b1);
      clr();
      // write and tick together: compare uses the old setting
      tim_word = tw(1'b1, 7'h45, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00);
      tim_wr = 1'b1; sec_tick = 1'b1; step();
      chk("R2 old setting used on write cycle", alarm_flag, 1'b1);
      clr();
      tick();
      chk("R2 new setting active", alarm_flag, 1'b0);
   endtask

   task automatic t_and();
      wr_tim(tw(1'b1, 7'h15, 1'b1, 7'h42, 1'b1, 1'b1, 6'h07));
      cur_sec = 7'h15; cur_min = 7'h42; cur_hour = 6'h07; cur_pm = 1'b0;
      cur_month = 5'h03;
      tick();
      chk("R2 R4 pm mismatch", alarm_flag, 1'b0);
      cur_min = 7'h41; cur_pm = 1'b1;
      tick();
      chk("R4 minute mismatch", alarm_flag, 1'b0);
      cur_min = 7'h42;
      tick();
      chk("R4 all enabled match", alarm_flag, 1'b1);
      clr();
   endtask

   task automatic t_calendar();
      wr_tim(tw(1'b0, 7'h00, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00));
      wr_cal(cw(1'b1, 5'h11, 1'b1, 6'h28));
      cur_month = 5'h11; cur_date = 6'h27; cur_sec = 7'h05;
      tick();
      chk("R3 date mismatch", alarm_flag, 1'b0);
      cur_date = 6'h28;
      tick();
      chk("R3 month and date match", alarm_flag, 1'b1);
      clr();
      wr_cal(cw(1'b0, 5'h11, 1'b0, 6'h28));
      tick();
      chk("R9 all enables zero", alarm_flag, 1'b0);
   endtask

   task automatic t_bad_time();
      wr_tim(tw(1'b1, 7'h20, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00));
      chk("R7 legal write", tim_bad, 1'b0);
      wr_tim(tw(1'b1, 7'h5A, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00));
      chk("R7 non-BCD seconds", tim_bad, 1'b1);
      cur_sec = 7'h20;
      tick();
      chk("R10 old time kept", alarm_flag, 1'b1);
      clr();
      wr_tim(tw(1'b1, 7'h10, 1'b1, 7'h60, 1'b0, 1'b0, 6'h00));
      chk("R7 minutes over 59", tim_bad, 1'b1);
      wr_tim(tw(1'b0, 7'h00, 1'b0, 7'h00, 1'b1, 1'b0, 6'h24));
      chk("R7 hour over 23", tim_bad, 1'b1);
      tick();
      chk("R10 still old time", alarm_flag, 1'b1);
      clr();
      wr_tim(tw(1'b1, 7'h20, 1'b0, 7'h7F, 1'b0, 1'b0, 6'h3F));
      chk("R7 disabled garbage ignored", tim_bad, 1'b0);
      wr_tim(tw(1'b0, 7'h00, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00));
   endtask

   task automatic t_bad_cal();
      wr_cal(cw(1'b1, 5'h05, 1'b0, 6'h00));
      chk("R8 legal month", cal_bad, 1'b0);
      wr_cal(cw(1'b1, 5'h13, 1'b0, 6'h00));
      chk("R8 month 13", cal_bad, 1'b1);
      wr_cal(cw(1'b1, 5'h00, 1'b0, 6'h00));
      chk("R8 month 0", cal_bad, 1'b1);
      wr_cal(cw(1'b0, 5'h00, 1'b1, 6'h00));
      chk("R8 date 0", cal_bad, 1'b1);
      wr_cal(cw(1'b0, 5'h00, 1'b1, 6'h32));
      chk("R8 date 32", cal_bad, 1'b1);
      cur_month = 5'h05;
      tick();
      chk("R10 old calendar kept", alarm_flag, 1'b1);
      clr();
      wr_cal(cw(1'b0, 5'h1F, 1'b1, 6'h31));
      chk("R8 date 31 legal", cal_bad, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_seconds();
      t_and();
      t_calendar();
      t_bad_time();
      t_bad_cal();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule